// File: doc/BRIEF.md
# Edge-Counting Timer

A 32-bit counter that advances from one of two sources. In timer mode a programmable prescaler divides the clock. The counter steps once every `prescale_i + 1` enabled clocks. In the three counting modes the prescaler is held cleared, and the counter steps directly on transitions of an external pin: rising, falling, or both.

The pin is chosen by a select field. Only select code 0 (pin 0) is usable. Codes 1, 2 and 3 are reserved and never produce counts.

Each pin passes through a two-stage synchronizer clocked by the main clock. An edge is found by comparing each synchronized sample with the one from the previous clock. The detector is primed only after the synchronizer has filled, so a pin that is already high at reset release is not counted.

An enable gates every increment. A synchronous clear zeroes both the prescaler and the counter. The counter wraps to zero after its all-ones value.

Top module: `edge_timer`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0.
- R2: With `mode_i` = 00 (timer), enable high and clear low, `count_o` rises by one every `prescale_i + 1` clocks, counted from a clear.
- R3: With `mode_i` = 01, `count_o` rises by one for each low-to-high transition of the selected pin.
- R4: With `mode_i` = 10, `count_o` rises by one for each high-to-low transition of the selected pin.
- R5: With `mode_i` = 11, `count_o` rises by one for each transition of the selected pin in either direction.
- R6: With `cap_sel_i` at 01, 10 or 11, pin activity never changes `count_o`. Only code 00 selects pin 0.
- R7: While `cnt_en_i` is low, `count_o` holds. Pin transitions made while disabled are not counted after the enable returns.
- R8: `cnt_clr_i` high forces `count_o` to 0 at the next clock, and it takes priority over an increment in the same cycle.
- R9: The counter wraps from all ones to 0. It never changes by more than one per clock.
- R10: A pin held high through reset produces no count in the rising-edge mode after reset release.
- R11: A pin transition applied between clocks is reflected in `count_o` after the third rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Enables all incrementing |
| cnt_clr_i | input | 1 | Synchronous clear of prescaler and counter |
| mode_i | input | 2 | 00 timer, 01 rising, 10 falling, 11 both edges |
| cap_sel_i | input | SEL_W (2) | Pin select; only 00 is valid |
| prescale_i | input | PRE_W (32) | Prescaler terminal value |
| cap_i | input | 2**SEL_W (4) | External count pins |
| count_o | output | CNT_W (32) | Counter value |

## Verification
The assertions assume that `cnt_clr_i`, `cnt_en_i`, `mode_i` and `cap_sel_i` are synchronous to `clk_i`. They also assume that a counting mode is judged one cycle after it is applied. Pin levels are assumed to last at least one clock, so consecutive samples never miss a transition.

The stimulus drives every input on the falling clock edge. It holds each random pin level for one to four clocks. It changes mode or select only while the pin is stable and no edge is in flight. Expected counts come from the driven level sequence and the prescaler period, not from any internal signal.

// File: rtl/et_pkg.sv
package et_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER = 2'b00,
    MODE_RISE  = 2'b01,
    MODE_FALL  = 2'b10,
    MODE_BOTH  = 2'b11
  } mode_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/et_sync.sv
module et_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic         ready_o
);
  localparam int FW = $clog2(STAGES + 1);

  logic [FW-1:0] fill_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else if (STAGES == 1) sh_q <= d_i[i];
      else sh_q <= {sh_q[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = sh_q[STAGES-1];
  end

  // ready once every stage holds a real sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_q <= '0;
    else if (fill_q != FW'(STAGES)) fill_q <= fill_q + 1'b1;
  end
  assign ready_o = (fill_q == FW'(STAGES));
endmodule

// File: rtl/et_edge_detect.sv
module et_edge_detect
  import et_pkg::*;
#(
  parameter int SEL_W      = 2,
  parameter int VALID_CAPS = 1,
  localparam int N         = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     lvl_i,
  input  logic             ready_i,
  input  logic [SEL_W-1:0] sel_i,
  output edge_t            edge_o
);
  logic [N-1:0] prev_q;
  logic         primed_q;
  logic [N-1:0] rise_v, fall_v;

  // history tracks every pin, so select changes cannot fake an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= lvl_i;
      primed_q <= ready_i;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign rise_v[i] = primed_q &  lvl_i[i] & ~prev_q[i];
    assign fall_v[i] = primed_q & ~lvl_i[i] &  prev_q[i];
  end

  always_comb begin
    edge_o = '0;
    if (int'(sel_i) < VALID_CAPS) begin
      edge_o.rise = rise_v[sel_i];
      edge_o.fall = fall_v[sel_i];
    end
  end
endmodule

// File: rtl/et_prescaler.sv
module et_prescaler #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic         hold_i,
  input  logic [W-1:0] limit_i,
  output logic         tick_o
);
  logic [W-1:0] pc_q;
  logic         term;

  assign term   = (pc_q == limit_i);
  assign tick_o = en_i & ~clr_i & ~hold_i & term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pc_q <= '0;
    else if (clr_i || hold_i)  pc_q <= '0;
    else if (en_i)             pc_q <= term ? '0 : pc_q + 1'b1;
  end
endmodule

// File: rtl/et_counter.sv
module et_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             count_o <= '0;
    else if (clr_i)          count_o <= '0;
    else if (en_i && inc_i)  count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/edge_timer.sv
module edge_timer
  import et_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int PRE_W       = 32,
  parameter int SEL_W       = 2,
  parameter int VALID_CAPS  = 1,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_CAP    = 1 << SEL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cnt_en_i,
  input  logic               cnt_clr_i,
  input  logic [1:0]         mode_i,
  input  logic [SEL_W-1:0]   cap_sel_i,
  input  logic [PRE_W-1:0]   prescale_i,
  input  logic [NUM_CAP-1:0] cap_i,
  output logic [CNT_W-1:0]   count_o
);
  logic [NUM_CAP-1:0] cap_s;
  logic               sync_ready;
  edge_t              ev;
  logic               tick;
  logic               counting;
  logic               inc;
  mode_e              mode;

  assign mode     = mode_e'(mode_i);
  assign counting = (mode != MODE_TIMER);

  et_sync #(.N(NUM_CAP), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(cap_i), .q_o(cap_s), .ready_o(sync_ready)
  );

  et_edge_detect #(.SEL_W(SEL_W), .VALID_CAPS(VALID_CAPS)) u_edge (
    .clk_i, .rst_ni, .lvl_i(cap_s), .ready_i(sync_ready),
    .sel_i(cap_sel_i), .edge_o(ev)
  );

  // counting modes bypass the prescaler entirely
  et_prescaler #(.W(PRE_W)) u_pre (
    .clk_i, .rst_ni, .en_i(cnt_en_i), .clr_i(cnt_clr_i),
    .hold_i(counting), .limit_i(prescale_i), .tick_o(tick)
  );

  always_comb begin
    unique case (mode)
      MODE_TIMER: inc = tick;
      MODE_RISE:  inc = ev.rise;
      MODE_FALL:  inc = ev.fall;
      MODE_BOTH:  inc = ev.rise | ev.fall;
      default:    inc = 1'b0;
    endcase
  end

  et_counter #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .en_i(cnt_en_i), .clr_i(cnt_clr_i),
    .inc_i(inc), .count_o(count_o)
  );
endmodule

// File: rtl/et_checker.sv
module et_checker #(
  parameter int CNT_W      = 32,
  parameter int SEL_W      = 2,
  parameter int VALID_CAPS = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_en_i,
  input logic             cnt_clr_i,
  input logic [1:0]       mode_i,
  input logic [SEL_W-1:0] cap_sel_i,
  input logic [CNT_W-1:0] count_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_zero: assert (count_o == '0);
  end

  a_r7_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && !cnt_clr_i) |=> $stable(count_o));

  a_r8_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> (count_o == '0));

  a_r9_step_or_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_clr_i |=> (CNT_W'(count_o - $past(count_o)) <= CNT_W'(1)));

  a_r6_reserved_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !cnt_clr_i && mode_i != 2'b00 && int'(cap_sel_i) >= VALID_CAPS)
      |=> $stable(count_o));
endmodule

bind edge_timer et_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W), .VALID_CAPS(VALID_CAPS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnt_en_i(cnt_en_i), .cnt_clr_i(cnt_clr_i),
  .mode_i(mode_i), .cap_sel_i(cap_sel_i), .count_o(count_o)
);

// File: tb/sim_edge_timer.sv
`timescale 1ns/1ps
module sim_edge_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cnt_en_i = 1'b1;
  logic        cnt_clr_i = 1'b0;
  logic [1:0]  mode_i = 2'b01;
  logic [1:0]  cap_sel_i = 2'b00;
  logic [31:0] prescale_i = '0;
  logic [3:0]  cap_i = 4'b0001;
  logic [31:0] count_o;
  logic [7:0]  count_n;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  edge_timer u0 (
    .clk_i, .rst_ni, .cnt_en_i, .cnt_clr_i, .mode_i, .cap_sel_i,
    .prescale_i, .cap_i, .count_o(count_o)
  );

  edge_timer #(.CNT_W(8)) u1 (
    .clk_i, .rst_ni, .cnt_en_i, .cnt_clr_i, .mode_i, .cap_sel_i,
    .prescale_i, .cap_i, .count_o(count_n)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_edge(input logic [1:0] m, input logic a, input logic b);
    if (a == b) return 0;
    case (m)
      2'b01:   return (b && !a) ? 1 : 0;
      2'b10:   return (!b && a) ? 1 : 0;
      2'b11:   return 1;
      default: return 0;
    endcase
  endfunction

  function automatic longint exp_timer(input int n, input int p);
    return n / (p + 1);
  endfunction

  task automatic pulse_clear();
    cnt_clr_i = 1'b1;
    cyc(1);
    cnt_clr_i = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    int exp_cnt;
    int c0;
    logic cur;
    void'($urandom(32'd2718));

    // R1 / R10: pin high through reset, rising mode
    cyc(3);
    check("R1", count_o, 0);
    rst_ni = 1'b1;
    cyc(8);
    check("R10", count_o, 0);

    // R11 latency
    cap_i = 4'b0000;
    cyc(6);
    c0 = int'(count_o);
    cap_i = 4'b0001;
    cyc(2);
    check("R11 after 2", count_o, c0);
    cyc(1);
    check("R11 after 3", count_o, c0 + 1);
    cyc(4);

    // R3 R4 R5: random pin sequences with noise on unused pins
    for (int m = 1; m <= 3; m++) begin
      mode_i = 2'(m);
      pulse_clear();
      exp_cnt = 0;
      cur = cap_i[0];
      for (int k = 0; k < 60; k++) begin
        logic nxt;
        nxt = ($urandom_range(0, 3) != 0) ? ~cur : cur;
        exp_cnt += exp_edge(2'(m), cur, nxt);
        cur = nxt;
        cap_i = {3'($urandom), cur};
        cyc($urandom_range(1, 4));
      end
      cyc(5);
      case (m)
        1: check("R3 rising", count_o, exp_cnt);
        2: check("R4 falling", count_o, exp_cnt);
        default: check("R5 both", count_o, exp_cnt);
      endcase
    end

    // R6: reserved select codes
    mode_i = 2'b11;
    for (int s = 1; s <= 3; s++) begin
      cap_sel_i = 2'(s);
      pulse_clear();
      for (int k = 0; k < 12; k++) begin
        cap_i = ~cap_i;
        cyc(2);
      end
      cyc(5);
      check("R6 reserved", count_o, 0);
    end
    cap_sel_i = 2'b00;
    cyc(5);
    check("R6 back to pin0", count_o, 0);

    // R7: disabled
    pulse_clear();
    cap_i[0] = ~cap_i[0];
    cyc(5);
    c0 = int'(count_o);
    check("R7 pre", c0, 1);
    cnt_en_i = 1'b0;
    for (int k = 0; k < 9; k++) begin
      cap_i[0] = ~cap_i[0];
      cyc(2);
    end
    mode_i = 2'b00;
    cyc(20);
    check("R7 disabled", count_o, c0);
    mode_i = 2'b11;
    cyc(3);
    cnt_en_i = 1'b1;
    cyc(6);
    check("R7 re-enabled", count_o, c0);

    // R2: timer mode with several prescale values
    for (int t = 0; t < 6; t++) begin
      int p, n;
      p = (t < 3) ? ((t == 2) ? 3 : t) : $urandom_range(2, 9);
      n = $urandom_range(20, 100);
      cnt_en_i = 1'b0;
      mode_i = 2'b00;
      prescale_i = 32'(p);
      pulse_clear();
      cnt_en_i = 1'b1;
      cyc(n);
      cnt_en_i = 1'b0;
      check("R2 timer", count_o, exp_timer(n, p));
    end

    // R8: clear beats increment
    prescale_i = '0;
    cnt_en_i = 1'b1;
    cyc(5);
    cnt_clr_i = 1'b1;
    cyc(1);
    check("R8 clear", count_o, 0);
    cnt_clr_i = 1'b0;
    cyc(3);
    check("R8 after clear", count_o, 3);

    // R9: wrap on 8-bit instance
    pulse_clear();
    cyc(300);
    cnt_en_i = 1'b0;
    check("R9 wrap narrow", count_n, 300 % 256);
    check("R9 wide", count_o, 300);

    summary();
  end
endmodule